// File: doc/BRIEF.md
# Reference-Loss Output Gating Controller

This block supervises a clock multiplier. A free-running system clock samples a one-cycle strobe that marks each reference-clock edge. When no strobe has arrived for a programmable number of cycles, the block declares the reference lost. It then decides whether the multiplied output clock may keep running and whether the unlock flag is raised. The loop signals that lock has been reacquired with a one-cycle lock pulse.

Two configuration bits shape the response. The skip bit lets a brief outage, and the whole relock that follows it, pass with the output running and no unlock flag. When the skip bit is clear, the unlock flag rises only when the reference comes back. The run-when-unlocked bit then decides whether the output keeps running during relock. An outage that lasts longer than the programmable skip window always forces the unlocked state. Both bits are captured once, when the reference is declared lost, so a change during an outage has no effect until the next outage.

A 3-bit minimum loop bandwidth code (1 Hz to 128 Hz) is registered and passed on to the loop. It has no effect on gating.

Top module: `refloss_gate_ctrl`

## Requirements
- R1: After reset, `unlock_flag`=1, `clk_out_en`=0 and `ref_lost`=0. This state holds, with the reference running, until the first accepted lock pulse.
- R2: Suppose the last `ref_tick` is sampled at edge e. Then `ref_lost` is 0 after edges e through e+`miss_limit`-1, and it is 1 after edge e+`miss_limit`. It returns to 0 after the edge that samples the next `ref_tick`.
- R3: While locked, `clk_out_en`=1 and `unlock_flag`=0. Both values hold through an outage no longer than `skip_limit` cycles, for as long as the reference stays lost.
- R4: With the captured skip bit at 0, a short outage raises `unlock_flag` after the second edge that follows the returning `ref_tick`, and not before.
- R5: While unlocked after an outage, `clk_out_en` equals the captured run-when-unlocked bit (1 = output runs, 0 = output gated off).
- R6: With the captured skip bit at 1, a short outage and the relock that follows it keep `clk_out_en`=1 and `unlock_flag`=0, whatever the value of the run-when-unlocked bit.
- R7: If `ref_lost` stays high for more than `skip_limit` cycles, `unlock_flag` rises while the reference is still absent. This holds whatever the skip bit.
- R8: A `lock_pulse` sampled while unlocked and with `ref_lost`=0 gives `unlock_flag`=0 and `clk_out_en`=1 after that same edge. A `lock_pulse` sampled while `ref_lost`=1 is ignored.
- R9: Both configuration bits are captured on the cycle the reference is declared lost. Changes made later in the same outage do not affect that outage.
- R10: `bw_sel_q` equals the `bw_sel` of the previous cycle (reset value 0), and its value never changes the gating.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_sys | input | 1 | Free-running system clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick | input | 1 | One-cycle strobe per reference edge |
| lock_pulse | input | 1 | One-cycle strobe: loop has reacquired lock |
| cfg_skip | input | 1 | Skip enable: ride through short outages |
| cfg_run_unlocked | input | 1 | Let the output run while unlocked |
| miss_limit | input | CNT_W | Cycles without a strobe before the reference counts as lost |
| skip_limit | input | CNT_W | Longest lost interval still treated as a short outage |
| bw_sel | input | BW_W | Minimum loop bandwidth code |
| clk_out_en | output | 1 | Output clock gate enable |
| unlock_flag | output | 1 | Unlocked status |
| ref_lost | output | 1 | Reference declared missing |
| bw_sel_q | output | BW_W | Registered bandwidth code for the loop |

## Verification
A wrong gating state shows at `clk_out_en` or `unlock_flag` within one or two clocks of the event that should have caused it. That event is the returning strobe, the end of the skip window or a lock pulse, so the bench samples on every cycle of each outage and at the exact edges that R2, R4 and R8 name. A stale or recaptured configuration bit stays hidden until the next unlocked interval, where `clk_out_en` shows the wrong value. A mid-outage change of configuration bits is therefore tested on its own. A skip-window counter that counts too far or not far enough shows up as the long-outage and short-outage cases swapping their outcomes.

// File: rtl/refgate_pkg.sv
package refgate_pkg;
  typedef enum logic [1:0] {
    ST_UNLOCK = 2'd0,
    ST_LOCKED = 2'd1,
    ST_HOLD   = 2'd2,
    ST_QUIET  = 2'd3
  } gate_st_t;
endpackage

// File: rtl/ref_activity_mon.sv
module ref_activity_mon #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ref_tick,
  input  logic [CNT_W-1:0] miss_limit,
  input  logic [CNT_W-1:0] skip_limit,
  output logic             ref_lost,
  output logic             outage_long
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] gap_q, gap_inc, lost_q;

  // saturating count of cycles since the last reference strobe
  always_comb gap_inc = (gap_q == CNT_MAX) ? gap_q : gap_q + CNT_ONE;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap_q    <= '0;
      ref_lost <= 1'b0;
    end else if (ref_tick) begin
      gap_q    <= '0;
      ref_lost <= 1'b0;
    end else begin
      gap_q    <= gap_inc;
      ref_lost <= (gap_inc >= miss_limit);
    end
  end

  // length of the current lost interval
  always_ff @(posedge clk) begin
    if (rst || !ref_lost) lost_q <= '0;
    else if (lost_q != CNT_MAX) lost_q <= lost_q + CNT_ONE;
  end

  assign outage_long = ref_lost && (lost_q >= skip_limit);

  AST_LOST_CLEARS: assert property (@(posedge clk) disable iff (rst)
    ref_tick |=> !ref_lost); // R2
  AST_LOST_NEEDS_GAP: assert property (@(posedge clk) disable iff (rst)
    $rose(ref_lost) |-> $past(!ref_tick)); // R2
endmodule

// File: rtl/gate_fsm.sv
module gate_fsm
  import refgate_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic ref_lost,
  input  logic outage_long,
  input  logic lock_pulse,
  input  logic cfg_skip,
  input  logic cfg_run_unlocked,
  output logic clk_out_en,
  output logic unlock_flag
);
  gate_st_t st_q, st_d;
  logic     skip_s, run_s, capture;

  always_comb begin
    st_d    = st_q;
    capture = 1'b0;
    case (st_q)
      ST_LOCKED: if (ref_lost) begin
        st_d    = ST_HOLD;
        capture = 1'b1;
      end
      ST_QUIET: begin
        if (ref_lost) begin
          st_d    = ST_HOLD;
          capture = 1'b1;
        end else if (lock_pulse) begin
          st_d = ST_LOCKED;
        end
      end
      ST_HOLD: begin
        if (outage_long)   st_d = ST_UNLOCK;
        else if (!ref_lost) st_d = skip_s ? ST_QUIET : ST_UNLOCK;
      end
      default: if (lock_pulse && !ref_lost) st_d = ST_LOCKED;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= ST_UNLOCK;
      skip_s      <= 1'b0;
      run_s       <= 1'b0;
      unlock_flag <= 1'b1;
      clk_out_en  <= 1'b0;
    end else begin
      st_q <= st_d;
      if (capture) begin
        skip_s <= cfg_skip;
        run_s  <= cfg_run_unlocked;
      end
      unlock_flag <= (st_d == ST_UNLOCK);
      clk_out_en  <= (st_d != ST_UNLOCK) || run_s;
    end
  end

  AST_RESET_GATED: assert property (@(posedge clk)
    rst |=> (unlock_flag && !clk_out_en)); // R1
  AST_RELOCK_NEXT: assert property (@(posedge clk) disable iff (rst)
    (unlock_flag && lock_pulse && !ref_lost) |=> (!unlock_flag && clk_out_en)); // R8
  AST_LOCK_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (unlock_flag && ref_lost) |=> unlock_flag); // R8
  AST_SKIP_QUIET: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_HOLD && skip_s && !outage_long && !ref_lost) |=> (!unlock_flag && clk_out_en)); // R6
  AST_LONG_UNLOCK: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_HOLD && outage_long) |=> unlock_flag); // R7
  AST_CFG_HELD: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_HOLD) |=> ($stable(skip_s) && $stable(run_s))); // R9
endmodule

// File: rtl/refloss_gate_ctrl.sv
module refloss_gate_ctrl #(
  parameter int CNT_W = 16,
  parameter int BW_W  = 3
) (
  input  logic             clk_sys,
  input  logic             rst,
  input  logic             ref_tick,
  input  logic             lock_pulse,
  input  logic             cfg_skip,
  input  logic             cfg_run_unlocked,
  input  logic [CNT_W-1:0] miss_limit,
  input  logic [CNT_W-1:0] skip_limit,
  input  logic [BW_W-1:0]  bw_sel,
  output logic             clk_out_en,
  output logic             unlock_flag,
  output logic             ref_lost,
  output logic [BW_W-1:0]  bw_sel_q
);
  logic outage_long;

  ref_activity_mon #(.CNT_W(CNT_W)) i_mon (
    .clk         (clk_sys),
    .rst         (rst),
    .ref_tick    (ref_tick),
    .miss_limit  (miss_limit),
    .skip_limit  (skip_limit),
    .ref_lost    (ref_lost),
    .outage_long (outage_long)
  );

  gate_fsm i_fsm (
    .clk              (clk_sys),
    .rst              (rst),
    .ref_lost         (ref_lost),
    .outage_long      (outage_long),
    .lock_pulse       (lock_pulse),
    .cfg_skip         (cfg_skip),
    .cfg_run_unlocked (cfg_run_unlocked),
    .clk_out_en       (clk_out_en),
    .unlock_flag      (unlock_flag)
  );

  always_ff @(posedge clk_sys) begin
    if (rst) bw_sel_q <= '0;
    else     bw_sel_q <= bw_sel;
  end

  AST_BW_PIPE: assert property (@(posedge clk_sys) disable iff (rst)
    1'b1 |=> (bw_sel_q == $past(bw_sel))); // R10
  AST_LOCKED_RUNS: assert property (@(posedge clk_sys) disable iff (rst)
    !unlock_flag |-> clk_out_en); // R3
endmodule

// File: tb/test_refloss_gate_ctrl.sv
module test_refloss_gate_ctrl;
  localparam int CNT_W = 16;
  localparam int BW_W  = 3;

  logic clk_sys = 1'b0;
  logic rst = 1'b1;
  logic ref_tick = 1'b0, lock_pulse = 1'b0, cfg_skip = 1'b0, cfg_run_unlocked = 1'b0;
  logic [CNT_W-1:0] miss_limit = CNT_W'(8);
  logic [CNT_W-1:0] skip_limit = CNT_W'(20);
  logic [BW_W-1:0]  bw_sel = '0;
  logic clk_out_en, unlock_flag, ref_lost;
  logic [BW_W-1:0] bw_sel_q;
  int checks = 0, errors = 0;

  always #4 clk_sys = ~clk_sys;

  refloss_gate_ctrl #(.CNT_W(CNT_W), .BW_W(BW_W)) i_refloss_gate_ctrl (
    .clk_sys(clk_sys), .rst(rst), .ref_tick(ref_tick), .lock_pulse(lock_pulse),
    .cfg_skip(cfg_skip), .cfg_run_unlocked(cfg_run_unlocked),
    .miss_limit(miss_limit), .skip_limit(skip_limit), .bw_sel(bw_sel),
    .clk_out_en(clk_out_en), .unlock_flag(unlock_flag), .ref_lost(ref_lost),
    .bw_sel_q(bw_sel_q));

  task automatic tick();
    @(negedge clk_sys);
  endtask

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic run_ref(int n);
    for (int i = 0; i < n; i++) begin
      ref_tick = (i % 4 == 0);
      tick();
    end
    ref_tick = 1'b0;
  endtask

  task automatic pulse_lock();
    lock_pulse = 1'b1;
    tick();
    lock_pulse = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) tick();
    rst = 1'b0;
    check("R1", "unlock after reset", unlock_flag, 1);
    check("R1", "gate after reset", clk_out_en, 0);
    check("R1", "lost after reset", ref_lost, 0);
    check("R10", "bw after reset", bw_sel_q, 0);
    run_ref(20);
    check("R1", "unlock before lock", unlock_flag, 1);
    check("R1", "gate before lock", clk_out_en, 0);
    pulse_lock();
    check("R8", "unlock after first lock", unlock_flag, 0);
    check("R8", "gate after first lock", clk_out_en, 1);
    run_ref(8);
  endtask

  task automatic t_miss_timing();
    cfg_skip = 1'b1;
    cfg_run_unlocked = 1'b0;
    ref_tick = 1'b1;
    tick();
    ref_tick = 1'b0;
    repeat (7) tick();
    check("R2", "lost one cycle early", ref_lost, 0);
    tick();
    check("R2", "lost at limit", ref_lost, 1);
    ref_tick = 1'b1;
    tick();
    ref_tick = 1'b0;
    check("R2", "lost clears after strobe", ref_lost, 0);
    run_ref(8);
    check("R6", "quiet relock keeps flag low", unlock_flag, 0);
    pulse_lock();
    run_ref(8);
    check("R3", "locked after quiet relock", clk_out_en, 1);
  endtask

  task automatic t_outage(bit skip, bit run_unl, bit long_gap);
    int bad = 0;
    int gap = long_gap ? 60 : 14;
    bit expect_unl = !skip || long_gap;
    cfg_skip = skip;
    cfg_run_unlocked = run_unl;
    ref_tick = 1'b1;
    tick();
    ref_tick = 1'b0;
    for (int i = 0; i < gap; i++) begin
      tick();
      if (!long_gap && (clk_out_en !== 1'b1 || unlock_flag !== 1'b0)) bad++;
    end
    if (!long_gap) check("R3", "running through short outage", bad, 0);
    else begin
      check("R7", "unlock during long outage", unlock_flag, 1);
      check("R5", "gate during long outage", clk_out_en, run_unl);
      pulse_lock();
      check("R8", "lock ignored while lost", unlock_flag, 1);
    end
    ref_tick = 1'b1;
    tick();
    ref_tick = 1'b0;
    if (!long_gap) check("R4", "no unlock on return edge", unlock_flag, 0);
    tick();
    if (!long_gap) check(skip ? "R6" : "R4", "unlock two edges after return", unlock_flag, expect_unl);
    bad = 0;
    for (int i = 0; i < 8; i++) begin
      ref_tick = (i % 4 == 2);
      tick();
      if (unlock_flag !== expect_unl) bad++;
      if (clk_out_en !== (expect_unl ? run_unl : 1'b1)) bad++;
    end
    ref_tick = 1'b0;
    check(expect_unl ? "R5" : "R6", "state during relock", bad, 0);
    pulse_lock();
    check("R8", "unlock clears on lock", unlock_flag, 0);
    check("R8", "gate opens on lock", clk_out_en, 1);
    run_ref(8);
  endtask

  task automatic t_cfg_change();
    cfg_skip = 1'b0;
    cfg_run_unlocked = 1'b1;
    ref_tick = 1'b1;
    tick();
    ref_tick = 1'b0;
    repeat (10) tick();
    cfg_skip = 1'b1;
    cfg_run_unlocked = 1'b0;
    repeat (3) tick();
    ref_tick = 1'b1;
    tick();
    ref_tick = 1'b0;
    run_ref(6);
    check("R9", "captured skip bit used", unlock_flag, 1);
    check("R9", "captured run bit used", clk_out_en, 1);
    pulse_lock();
    run_ref(8);
  endtask

  task automatic t_bandwidth();
    int bad = 0;
    for (int v = 0; v < 8; v++) begin
      bw_sel = BW_W'(v);
      ref_tick = (v % 4 == 0);
      tick();
      if (bw_sel_q !== BW_W'(v)) bad++;
      if (clk_out_en !== 1'b1 || unlock_flag !== 1'b0) bad++;
    end
    ref_tick = 1'b0;
    check("R10", "bandwidth pipe and no gating effect", bad, 0);
  endtask

  initial begin
    tick();
    t_reset();
    t_miss_timing();
    for (int s = 0; s < 2; s++)
      for (int u = 0; u < 2; u++)
        for (int l = 0; l < 2; l++)
          t_outage(s[0], u[0], l[0]);
    t_cfg_change();
    t_bandwidth();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_sys);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule